// File: doc/BRIEF.md
# Dual-Mode Modular / Complex Multiplier

This block is a pipelined arithmetic unit that spends three shared multipliers on one of two jobs, chosen per operation by a select input. With the select high it reduces the product of two unsigned residues modulo a caller-supplied modulus `q`, using a Barrett estimate. The caller supplies the precomputed constant `m = floor(2^k / q)` and the shift `k = 2*ceil(log2 q)`. With the select low it multiplies two signed fixed-point complex numbers with three real products instead of four.

In modular mode the first multiplier squares off `a_r*b_r`. The other two multiply the low half and the high half of that product by `m`. The two half-products are recombined, shifted right by `k`, multiplied by `q` and subtracted. One conditional subtraction of `q` finishes the result. In complex mode the same three multipliers form `a_r*b_r`, `a_i*b_i` and `(a_r+a_i)*(b_r+b_i)`. The real part is the difference of the first two. The imaginary part is the third product minus the other two.

The select travels down the pipeline with its operands, so the two modes can be interleaved on consecutive cycles. A valid flag marks each accepted operation and its result.

Top module: `dualmode_mult`

## Requirements
- R1: An operation accepted with `in_valid`=1 on a rising edge is presented, with `out_valid`=1, after exactly three rising edges counting the accepting one. `out_valid` is 0 in the two cycles before that.
- R2: While `rst` is high and after it is released, `out_valid`, `c_r` and `c_i` are 0 until the first result arrives.
- R3: With `sel`=1, and given `a_r < q`, `b_r < q`, `m = floor(2^k/q)` and `k = 2*ceil(log2 q)`, `c_r` equals `(a_r*b_r) mod q`.
- R4: With `sel`=1, `c_i` is 0.
- R5: With `sel`=1, operands equal to `q-1` on both sides give `c_r` = 1, for moduli up to `2^W - 1`.
- R6: With `sel`=0, the operands are W-bit two's complement and `c_r` equals `a_r*b_r - a_i*b_i` as a (2W+1)-bit two's complement value.
- R7: With `sel`=0, `c_i` equals `a_r*b_i + a_i*b_r` as a (2W+1)-bit two's complement value.
- R8: With `sel`=0, the most negative operand `-2^(W-1)` in every position gives `c_i = 2^(2W-1)` and `c_r = 0` with no overflow.
- R9: The mode is taken per operation: modular and complex operations issued on consecutive cycles each produce the result of their own mode.
- R10: In a cycle with no result leaving the pipeline, `c_r` and `c_i` keep their values and `out_valid` is 0, whatever the inputs do meanwhile.
- R11: Every modular result is strictly less than the `q` supplied with its operation.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous active-high reset |
| in_valid | input | 1 | Accept an operation this cycle |
| sel | input | 1 | 1 = modular multiply, 0 = complex multiply |
| a_r | input | W | Residue A (modular) or real part of A (complex) |
| a_i | input | W | Imaginary part of A (complex mode only) |
| b_r | input | W | Residue B (modular) or real part of B (complex) |
| b_i | input | W | Imaginary part of B (complex mode only) |
| q | input | W | Modulus |
| m | input | W+1 | Barrett constant floor(2^k/q) |
| k | input | clog2(2W+1) | Barrett shift |
| out_valid | output | 1 | Result present on c_r / c_i |
| c_r | output | 2W+1 | Modular residue, or real part of the complex product |
| c_i | output | 2W+1 | Zero (modular), or imaginary part of the complex product |

## Verification
Residues of `q-1` on several moduli, up to the largest 16-bit prime, drive the Barrett estimate to its worst error. A design that drops the `<< W` on the high half-product, or that skips the final correction, returns a value at or above `q`. Complex operands at `-2^(W-1)` push the imaginary sum to exactly `2^(2W-1)`. A pre-adder without its guard bit, or an output one bit too narrow, wraps that result to a negative number. A stream alternating the two modes every cycle exposes a select that is not carried with its data, because each result would then be decoded in the wrong mode. Idle cycles with moving inputs show whether the output registers load when no result is present.

// File: rtl/dmm_pkg.sv
package dmm_pkg;

    typedef enum logic {
        MODE_CPLX = 1'b0,
        MODE_MOD  = 1'b1
    } mode_e;

    function automatic int shift_bits(input int width);
        return $clog2(2 * width + 1);
    endfunction

endpackage

// File: rtl/dm_mul.sv
module dm_mul #(
    parameter int N = 18
) (
    input  logic signed [N-1:0]   x,
    input  logic signed [N-1:0]   y,
    output logic signed [2*N-1:0] p
);
    always_comb p = x * y;
endmodule

// File: rtl/dm_finish.sv
module dm_finish
    import dmm_pkg::*;
#(
    parameter int W  = 16,
    parameter int KW = 6,
    parameter int PW = 2 * (W + 2)
) (
    input  logic                 clk,
    input  logic                 rst,
    input  logic                 v_in,
    input  mode_e                mode_in,
    input  logic signed [PW-1:0] p1,
    input  logic signed [PW-1:0] p2,
    input  logic signed [PW-1:0] p3,
    input  logic [W-1:0]         q_in,
    input  logic [KW-1:0]        k_in,
    output logic                 v_out,
    output logic [2*W:0]         res_r,
    output logic [2*W:0]         res_i
);
    localparam int OW = 2 * W + 1;
    localparam int AW = 3 * W + 2;

    logic [AW-1:0] acc;
    logic [W:0]    est;
    logic [OW-1:0] estq;
    logic [OW-1:0] rem;
    logic [OW-1:0] mod_res;
    logic [OW-1:0] cr_c;
    logic [OW-1:0] ci_c;
    logic [OW-1:0] nxt_r;
    logic [OW-1:0] nxt_i;

    always_comb begin
        // low half-product plus high half-product weighted by 2^W
        acc     = AW'(p2[2*W:0]) + (AW'(p3[2*W:0]) << W);
        est     = (W+1)'(acc >> k_in);
        estq    = OW'(est) * OW'(q_in);
        rem     = {1'b0, p1[2*W-1:0]} - estq;
        mod_res = (rem >= OW'(q_in)) ? rem - OW'(q_in) : rem;
        cr_c    = OW'(p1) - OW'(p2);
        ci_c    = OW'(p3) - OW'(p1) - OW'(p2);
        if (mode_in == MODE_MOD) begin
            nxt_r = mod_res;
            nxt_i = '0;
        end else begin
            nxt_r = cr_c;
            nxt_i = ci_c;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            v_out <= 1'b0;
            res_r <= '0;
            res_i <= '0;
        end else begin
            v_out <= v_in;
            if (v_in) begin
                res_r <= nxt_r;
                res_i <= nxt_i;
            end
        end
    end

    // Barrett remainder before correction stays below 2q
    assert_barrett_bound_R3: assert property (@(posedge clk) disable iff (rst)
        (v_in && mode_in == MODE_MOD) |-> (rem < {1'b0, q_in, 1'b0}))
        else $error("Barrett remainder out of range");

    // reduced residue below the modulus it was computed for
    assert_mod_range_R11: assert property (@(posedge clk) disable iff (rst)
        (v_in && mode_in == MODE_MOD) |=> (res_r < OW'($past(q_in))))
        else $error("modular result not below q");

    assert_mod_imag_zero_R4: assert property (@(posedge clk) disable iff (rst)
        (v_in && mode_in == MODE_MOD) |=> (res_i == '0))
        else $error("modular result has nonzero imaginary part");
endmodule

// File: rtl/dualmode_mult.sv
module dualmode_mult
    import dmm_pkg::*;
#(
    parameter int W = 16
) (
    input  logic                        clk,
    input  logic                        rst,
    input  logic                        in_valid,
    input  logic                        sel,
    input  logic [W-1:0]                a_r,
    input  logic [W-1:0]                a_i,
    input  logic [W-1:0]                b_r,
    input  logic [W-1:0]                b_i,
    input  logic [W-1:0]                q,
    input  logic [W:0]                  m,
    input  logic [shift_bits(W)-1:0]    k,
    output logic                        out_valid,
    output logic [2*W:0]                c_r,
    output logic [2*W:0]                c_i
);
    localparam int KW = shift_bits(W);
    localparam int MW = W + 2;
    localparam int PW = 2 * MW;
    localparam int SW = W + 1;

    // ---------------- stage 1: first product and pre-adders
    logic signed [MW-1:0] x0, y0;
    logic signed [PW-1:0] p0;
    logic signed [SW-1:0] sum_a, sum_b;

    always_comb begin
        if (sel) begin
            x0 = MW'(a_r);
            y0 = MW'(b_r);
        end else begin
            x0 = MW'($signed(a_r));
            y0 = MW'($signed(b_r));
        end
        sum_a = SW'($signed(a_r)) + SW'($signed(a_i));
        sum_b = SW'($signed(b_r)) + SW'($signed(b_i));
    end

    dm_mul #(.N(MW)) u_mul0 (.x(x0), .y(y0), .p(p0));

    logic                 s1_v;
    mode_e                s1_mode;
    logic signed [PW-1:0] s1_p1;
    logic signed [W-1:0]  s1_ai, s1_bi;
    logic signed [SW-1:0] s1_sa, s1_sb;
    logic [W-1:0]         s1_q;
    logic [W:0]           s1_m;
    logic [KW-1:0]        s1_k;

    always_ff @(posedge clk) begin
        if (rst) begin
            s1_v    <= 1'b0;
            s1_mode <= MODE_CPLX;
            s1_p1   <= '0;
            s1_ai   <= '0;
            s1_bi   <= '0;
            s1_sa   <= '0;
            s1_sb   <= '0;
            s1_q    <= '0;
            s1_m    <= '0;
            s1_k    <= '0;
        end else begin
            s1_v <= in_valid;
            if (in_valid) begin
                s1_mode <= sel ? MODE_MOD : MODE_CPLX;
                s1_p1   <= p0;
                s1_ai   <= $signed(a_i);
                s1_bi   <= $signed(b_i);
                s1_sa   <= sum_a;
                s1_sb   <= sum_b;
                s1_q    <= q;
                s1_m    <= m;
                s1_k    <= k;
            end
        end
    end

    // ---------------- stage 2: two shared multipliers, operands steered by mode
    logic signed [MW-1:0] mx [2];
    logic signed [MW-1:0] my [2];
    logic signed [PW-1:0] mp [2];

    always_comb begin
        if (s1_mode == MODE_MOD) begin
            mx[0] = MW'(s1_p1[W-1:0]);
            mx[1] = MW'(s1_p1[2*W-1:W]);
            my[0] = MW'(s1_m);
            my[1] = MW'(s1_m);
        end else begin
            mx[0] = MW'(s1_ai);
            mx[1] = MW'(s1_sa);
            my[0] = MW'(s1_bi);
            my[1] = MW'(s1_sb);
        end
    end

    for (genvar g = 0; g < 2; g++) begin : g_shared
        dm_mul #(.N(MW)) u_mul (.x(mx[g]), .y(my[g]), .p(mp[g]));
    end

    logic                 s2_v;
    mode_e                s2_mode;
    logic signed [PW-1:0] s2_p1, s2_p2, s2_p3;
    logic [W-1:0]         s2_q;
    logic [KW-1:0]        s2_k;

    always_ff @(posedge clk) begin
        if (rst) begin
            s2_v    <= 1'b0;
            s2_mode <= MODE_CPLX;
            s2_p1   <= '0;
            s2_p2   <= '0;
            s2_p3   <= '0;
            s2_q    <= '0;
            s2_k    <= '0;
        end else begin
            s2_v <= s1_v;
            if (s1_v) begin
                s2_mode <= s1_mode;
                s2_p1   <= s1_p1;
                s2_p2   <= mp[0];
                s2_p3   <= mp[1];
                s2_q    <= s1_q;
                s2_k    <= s1_k;
            end
        end
    end

    // ---------------- stage 3: reduction or recombination
    dm_finish #(.W(W), .KW(KW), .PW(PW)) u_finish (
        .clk     (clk),
        .rst     (rst),
        .v_in    (s2_v),
        .mode_in (s2_mode),
        .p1      (s2_p1),
        .p2      (s2_p2),
        .p3      (s2_p3),
        .q_in    (s2_q),
        .k_in    (s2_k),
        .v_out   (out_valid),
        .res_r   (c_r),
        .res_i   (c_i)
    );

    assert_operand_range_R3: assert property (@(posedge clk) disable iff (rst)
        (in_valid && sel) |-> (a_r < q && b_r < q))
        else $error("modular operand not below q");

    assert_valid_chain_R1: assert property (@(posedge clk) disable iff (rst)
        s1_v |=> s2_v)
        else $error("valid lost between stages");

    assert_result_follows_R1: assert property (@(posedge clk) disable iff (rst)
        s2_v |=> out_valid)
        else $error("result valid missing");

    assert_hold_idle_R10: assert property (@(posedge clk) disable iff (rst)
        !s2_v |=> (!out_valid && $stable(c_r) && $stable(c_i)))
        else $error("outputs moved without a result");
endmodule

// File: tb/dualmode_mult_tb.sv
module dualmode_mult_tb_top;
    localparam int W  = 16;
    localparam int KW = $clog2(2 * W + 1);
    localparam int OW = 2 * W + 1;

    logic          clk = 1'b0;
    logic          rst;
    logic          in_valid;
    logic          sel;
    logic [W-1:0]  a_r, a_i, b_r, b_i, q;
    logic [W:0]    m;
    logic [KW-1:0] k;
    logic          out_valid;
    logic [OW-1:0] c_r, c_i;

    int  checks = 0;
    int  errors = 0;
    bit  done   = 1'b0;

    always #10 clk = ~clk;

    dualmode_mult #(.W(W)) dut_i (
        .clk(clk), .rst(rst), .in_valid(in_valid), .sel(sel),
        .a_r(a_r), .a_i(a_i), .b_r(b_r), .b_i(b_i),
        .q(q), .m(m), .k(k),
        .out_valid(out_valid), .c_r(c_r), .c_i(c_i)
    );

    task automatic check(input string req, input longint act, input longint exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s: actual %0d expected %0d", req, act, exp);
        end
    endtask

    function automatic longint sx(input logic [OW-1:0] v);
        return longint'($signed(v));
    endfunction

    task automatic set_mod(input int unsigned qq, input int unsigned x, input int unsigned y);
        int lg;
        lg  = $clog2(qq);
        sel = 1'b1;
        q   = W'(qq);
        k   = KW'(2 * lg);
        m   = (W+1)'((64'd1 << (2 * lg)) / qq);
        a_r = W'(x);
        b_r = W'(y);
        a_i = 16'h5a5a;
        b_i = 16'ha5a5;
    endtask

    task automatic set_cplx(input int ar, input int ai, input int br, input int bi);
        sel = 1'b0;
        a_r = W'(ar); a_i = W'(ai); b_r = W'(br); b_i = W'(bi);
        q = 16'd3329; m = '0; k = '0;
    endtask

    // issue one operation, checks latency (R1), returns outputs
    task automatic issue(output logic [OW-1:0] rr, output logic [OW-1:0] ri);
        in_valid = 1'b1;
        @(negedge clk);
        in_valid = 1'b0;
        check("R1 no early valid", out_valid, 0);
        @(negedge clk);
        check("R1 no early valid", out_valid, 0);
        @(negedge clk);
        check("R1 valid at third edge", out_valid, 1);
        rr = c_r;
        ri = c_i;
    endtask

    task automatic mod_op(input string req, input int unsigned qq,
                          input int unsigned x, input int unsigned y);
        logic [OW-1:0] rr, ri;
        longint exp;
        set_mod(qq, x, y);
        issue(rr, ri);
        exp = (longint'(x) * longint'(y)) % longint'(qq);
        check(req, longint'(rr), exp);
        check("R4 imag zero", longint'(ri), 0);
        check("R11 below q", longint'(rr < OW'(qq)), 1);
    endtask

    task automatic cplx_op(input string req, input int ar, input int ai,
                           input int br, input int bi);
        logic [OW-1:0] rr, ri;
        set_cplx(ar, ai, br, bi);
        issue(rr, ri);
        check({req, " R6 real"}, sx(rr), longint'(ar) * br - longint'(ai) * bi);
        check({req, " R7 imag"}, sx(ri), longint'(ar) * bi + longint'(ai) * br);
    endtask

    task automatic t_reset();
        rst = 1'b1; in_valid = 1'b0;
        set_cplx(0, 0, 0, 0);
        repeat (3) @(negedge clk);
        check("R2 valid in reset", out_valid, 0);
        rst = 1'b0;
        @(negedge clk);
        check("R2 valid after reset", out_valid, 0);
        check("R2 c_r after reset", longint'(c_r), 0);
        check("R2 c_i after reset", longint'(c_i), 0);
    endtask

    task automatic t_modular();
        mod_op("R3 q3329", 3329, 1234, 2345);
        mod_op("R3 zero", 3329, 0, 3328);
        mod_op("R3 one", 3329, 1, 1);
        mod_op("R3 q12289", 12289, 12000, 777);
        mod_op("R3 q8191", 8191, 8190, 4096);
        mod_op("R5 q3329", 3329, 3328, 3328);
        mod_op("R5 q12289", 12289, 12288, 12288);
        mod_op("R5 q65521", 65521, 65520, 65520);
        mod_op("R3 q65521", 65521, 65000, 31337);
    endtask

    task automatic t_complex();
        cplx_op("basic", 3, 4, 5, -6);
        cplx_op("neg", -1200, 700, -33, -9999);
        cplx_op("pure real", 32767, 0, -32767, 0);
        cplx_op("R8 all min", -32768, -32768, -32768, -32768);
        cplx_op("R8 min max", -32768, 32767, -32768, 32767);
        cplx_op("R8 max min", 32767, -32768, 32767, -32768);
    endtask

    task automatic t_interleave();
        // four ops back to back, alternating modes (R9)
        logic          md [4];
        int            xa [4], xb [4], xc [4], xd [4], qv [4];
        longint        er [4], ei [4];
        md[0] = 1; xa[0] = 3328; xb[0] = 2; qv[0] = 3329;
        md[1] = 0; xa[1] = -32768; xb[1] = 100; xc[1] = -32768; xd[1] = -7;
        md[2] = 1; xa[2] = 12288; xb[2] = 5; qv[2] = 12289;
        md[3] = 0; xa[3] = 17; xb[3] = -3; xc[3] = 2; xd[3] = 9;
        for (int i = 0; i < 4; i++) begin
            if (md[i]) begin
                er[i] = (longint'(xa[i]) * xb[i]) % qv[i];
                ei[i] = 0;
            end else begin
                er[i] = longint'(xa[i]) * xc[i] - longint'(xb[i]) * xd[i];
                ei[i] = longint'(xa[i]) * xd[i] + longint'(xb[i]) * xc[i];
            end
        end
        for (int i = 0; i < 7; i++) begin
            if (i >= 3) begin
                check("R9 stream valid", out_valid, 1);
                check("R9 stream real", md[i-3] ? longint'(c_r) : sx(c_r), er[i-3]);
                check("R9 stream imag", sx(c_i), ei[i-3]);
            end
            if (i < 4) begin
                if (md[i]) set_mod(qv[i], xa[i], xb[i]);
                else set_cplx(xa[i], xb[i], xc[i], xd[i]);
                in_valid = 1'b1;
            end else begin
                in_valid = 1'b0;
            end
            @(negedge clk);
        end
        check("R1 stream ends", out_valid, 0);
    endtask

    task automatic t_hold();
        logic [OW-1:0] rr, ri;
        cplx_op("hold setup", -500, 321, 77, -4321);
        rr = c_r; ri = c_i;
        for (int i = 0; i < 5; i++) begin
            set_cplx(i * 1000 + 1, -i, 9, i);
            sel = i[0];
            @(negedge clk);
            check("R10 idle valid", out_valid, 0);
            check("R10 idle c_r held", longint'(c_r), longint'(rr));
            check("R10 idle c_i held", longint'(c_i), longint'(ri));
        end
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            checks++;
            errors++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end

    initial begin
        t_reset();
        t_modular();
        t_complex();
        t_interleave();
        t_hold();
        done = 1'b1;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end
endmodule